// File: doc/BRIEF.md
# Sync-Anchored Raster Timing Generator

This block produces the horizontal and vertical timing strobes for a raster display. Two counters run in clock units. The horizontal counter counts character clocks, and each character clock carries a fixed number of pixels. The vertical counter counts scanlines. Both counters restart at zero at the leading edge of sync. Every edge of a line or a frame is placed by a programmed position measured from that restart: where sync ends, where blanking ends, where blanking starts again, and the total length.

Eight 16-bit timing words are loaded through a simple write port. Writes land in a shadow copy. The shadow copy becomes live only when a frame wraps, so a frame is never built from mixed parameters. If the live words do not form a strictly rising sequence on both axes, the block flags an error, holds both counters at zero and keeps the display blanked. While the error is present, each new write is taken up at once. The blanking and sync flags are registered from the next counter value, so each flag is decided one clock ahead. The vertical flags therefore change only on the first clock of a scanline.

Top module: `raster_timing_gen`

## Requirements
- R1: Write address selects the word: 0 horizontal sync end (HSE), 1 horizontal blank end (HBE), 2 horizontal blank start (HBS), 3 horizontal total (HT), 4 to 7 the same four for the vertical axis (VSE, VBE, VBS, VT). A write changes the live timing only from the first clock after the current frame wraps, unless R5's error is present, in which case it applies on the next clock.
- R2: Each line lasts HT clocks and each frame lasts VT lines. `line_start` is high exactly on horizontal count 0, where horizontal sync is asserted.
- R3: Horizontal sync is asserted for counts 0 to HSE-1. Vertical sync is asserted for lines 0 to VSE-1.
- R4: Blanking is asserted on each axis for counts below its blank end and for counts from its blank start upward. `blank` is the OR of both axes. `active` is its inverse, so a frame has VBS-VBE active lines.
- R5: The timing is valid only if 0 < SE < BE < BS < T on both axes. Otherwise `cfg_err`=1, `blank`=1, `active`=0, both syncs are at their inactive level, the pulses are low and the counters are held at 0.
- R6: `hsync_pol`/`vsync_pol` = 1 makes the sync pin high when asserted. A value of 0 inverts the pin.
- R7: `csync` is `hsync` XOR `vsync` when `csync_xor`=1, and `hsync` OR `vsync` when `csync_xor`=0, taken at the pins.
- R8: The vertical sync state changes only on a clock where `line_start` is high.
- R9: `frame_start` is high exactly on horizontal count 0 of line 0.
- R10: During active video `col` = horizontal count minus HBE, `row` = line minus VBE and `pix_x` = `col` times PPC. All three are 0 outside active video.
- R11: While `rst` is high, both counters are 0, `blank`=1, `active`=0, the syncs are inactive and the pulses are low. The timing resets to HSE=2, HBE=4, HBS=14, HT=16, VSE=1, VBE=2, VBS=8, VT=9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Timing word write strobe |
| wr_addr | input | 3 | Timing word index (R1) |
| wr_data | input | 16 | Timing word value |
| hsync_pol | input | 1 | Horizontal sync pin polarity, 1 = active high |
| vsync_pol | input | 1 | Vertical sync pin polarity, 1 = active high |
| csync_xor | input | 1 | Composite sync combine mode, 1 = XOR, 0 = OR |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| csync | output | 1 | Composite sync for the green channel |
| blank | output | 1 | Blanking strobe |
| active | output | 1 | Active video strobe |
| line_start | output | 1 | First clock of a line |
| frame_start | output | 1 | First clock of a frame |
| cfg_err | output | 1 | Live timing words out of order |
| col | output | 16 | Character-clock column within active video |
| row | output | 16 | Line within active video |
| pix_x | output | 18 | Pixel column, col times PPC |

## Verification
The properties assume that the live words change only at a frame wrap or while the error is present. They also assume that a vertical flag change after a valid-to-valid transition can only come from a counter step at a line boundary. Both hold because the write port feeds the shadow copy only. The stimulus writes words at arbitrary clocks, including mid-frame and while the error is present. It sweeps many small ordered configurations and a deliberately misordered one. It varies both polarities and the combine mode, so that every edge position and every output mode is compared against an arithmetic model of the counts.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int unsigned RW     = 16;
    localparam int unsigned NREG   = 8;
    localparam int unsigned AW     = $clog2(NREG);

    typedef logic [RW-1:0] word_t;

    // member order puts sync_end at the lowest word, matching write addresses
    typedef struct packed {
        word_t total;
        word_t blank_start;
        word_t blank_end;
        word_t sync_end;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t v;
        axis_cfg_t h;
    } timing_cfg_t;

    typedef struct packed {
        logic sync;
        logic blank;
    } axis_flags_t;

    localparam timing_cfg_t DEF_TIMING = '{
        v: '{total: 16'd9,  blank_start: 16'd8,  blank_end: 16'd2, sync_end: 16'd1},
        h: '{total: 16'd16, blank_start: 16'd14, blank_end: 16'd4, sync_end: 16'd2}
    };

    function automatic logic axis_ok(axis_cfg_t c);
        return (c.sync_end != '0) && (c.sync_end < c.blank_end) &&
               (c.blank_end < c.blank_start) && (c.blank_start < c.total);
    endfunction

    function automatic axis_flags_t axis_decode(word_t cnt, axis_cfg_t c);
        axis_flags_t f;
        f.sync  = cnt < c.sync_end;
        f.blank = (cnt < c.blank_end) || (cnt >= c.blank_start);
        return f;
    endfunction

endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
    import vtg_pkg::*;
#(
    parameter timing_cfg_t DEF = DEF_TIMING
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          commit,
    output timing_cfg_t   shadow,
    output timing_cfg_t   live
);

    logic [NREG-1:0][RW-1:0] sh_q;
    logic [NREG-1:0][RW-1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= DEF;
            live_q <= DEF;
        end else begin
            if (commit) begin
                live_q <= sh_q;
            end
            if (wr_en) begin
                sh_q[wr_addr] <= wr_data;
            end
        end
    end

    assign shadow = timing_cfg_t'(sh_q);
    assign live   = timing_cfg_t'(live_q);

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        step,
    input  axis_cfg_t   cfg_cur,
    input  axis_cfg_t   cfg_nxt,
    output word_t       cnt,
    output logic        wrap,
    output axis_flags_t flags
);

    word_t       cnt_q;
    word_t       cnt_d;
    axis_flags_t flags_q;

    assign wrap = step && (cnt_q == cfg_cur.total - 1'b1);

    always_comb begin
        if (hold || wrap) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // flags are decided from the next count, one clock ahead of use
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flags_q <= '{sync: 1'b1, blank: 1'b1};
        end else begin
            cnt_q   <= cnt_d;
            flags_q <= axis_decode(cnt_d, cfg_nxt);
        end
    end

    assign cnt   = cnt_q;
    assign flags = flags_q;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned PPC     = 4,
    parameter timing_cfg_t DEF_CFG = DEF_TIMING,
    localparam int unsigned PXW    = RW + $clog2(PPC)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [15:0]    wr_data,
    input  logic           hsync_pol,
    input  logic           vsync_pol,
    input  logic           csync_xor,
    output logic           hsync,
    output logic           vsync,
    output logic           csync,
    output logic           blank,
    output logic           active,
    output logic           line_start,
    output logic           frame_start,
    output logic           cfg_err,
    output logic [15:0]    col,
    output logic [15:0]    row,
    output logic [PXW-1:0] pix_x
);

    timing_cfg_t sh_cfg;
    timing_cfg_t live_cfg;
    timing_cfg_t nxt_cfg;
    logic        cfg_bad;
    logic        commit;
    logic        h_wrap;
    logic        v_wrap;
    word_t       h_cnt;
    word_t       v_cnt;
    axis_flags_t h_flags;
    axis_flags_t v_flags;
    logic        out_mask;
    logic        h_sync_raw;
    logic        v_sync_raw;
    logic [1:0]  sync_act;
    logic [1:0]  sync_pol;
    logic [1:0]  sync_pin;

    assign cfg_bad = !(axis_ok(live_cfg.h) && axis_ok(live_cfg.v));
    assign commit  = cfg_bad || v_wrap;
    assign nxt_cfg = commit ? sh_cfg : live_cfg;

    vtg_cfg_regs #(.DEF(DEF_CFG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .shadow  (sh_cfg),
        .live    (live_cfg)
    );

    vtg_axis u_hax (
        .clk     (clk),
        .rst     (rst),
        .hold    (cfg_bad),
        .step    (1'b1),
        .cfg_cur (live_cfg.h),
        .cfg_nxt (nxt_cfg.h),
        .cnt     (h_cnt),
        .wrap    (h_wrap),
        .flags   (h_flags)
    );

    vtg_axis u_vax (
        .clk     (clk),
        .rst     (rst),
        .hold    (cfg_bad),
        .step    (h_wrap),
        .cfg_cur (live_cfg.v),
        .cfg_nxt (nxt_cfg.v),
        .cnt     (v_cnt),
        .wrap    (v_wrap),
        .flags   (v_flags)
    );

    assign h_sync_raw = h_flags.sync;
    assign v_sync_raw = v_flags.sync;
    assign out_mask   = cfg_bad || rst;

    assign blank       = out_mask || h_flags.blank || v_flags.blank;
    assign active      = !blank;
    assign line_start  = !out_mask && (h_cnt == '0);
    assign frame_start = line_start && (v_cnt == '0);
    assign cfg_err     = cfg_bad;

    assign sync_act = {v_sync_raw && !out_mask, h_sync_raw && !out_mask};
    assign sync_pol = {vsync_pol, hsync_pol};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        assign sync_pin[g] = sync_pol[g] ? sync_act[g] : !sync_act[g];
    end

    assign hsync = sync_pin[0];
    assign vsync = sync_pin[1];
    assign csync = csync_xor ? (hsync ^ vsync) : (hsync | vsync);

    assign col   = active ? (h_cnt - live_cfg.h.blank_end) : '0;
    assign row   = active ? (v_cnt - live_cfg.v.blank_end) : '0;
    assign pix_x = PXW'(col) * PXW'(PPC);

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_bad,
    input logic  line_start,
    input logic  h_sync_raw,
    input logic  v_sync_raw,
    input word_t h_cnt,
    input word_t h_tot
);

    // R2: every line opens with horizontal sync asserted
    a_r2_sync_at_line_start: assert property (@(posedge clk) disable iff (rst)
        line_start |-> h_sync_raw);

    // R2: the horizontal count stays inside the programmed line length
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        !cfg_bad |-> (h_cnt < h_tot));

    // R5: counters stay parked while the timing is out of order
    a_r5_counters_held: assert property (@(posedge clk) disable iff (rst)
        (cfg_bad && $past(cfg_bad)) |-> (h_cnt == '0));

    // R8: vertical sync moves only on a scanline boundary
    a_r8_vsync_on_line_edge: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bad && !$past(cfg_bad) && (v_sync_raw != $past(v_sync_raw))) |-> line_start);

endmodule

bind raster_timing_gen vtg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_bad    (cfg_bad),
    .line_start (line_start),
    .h_sync_raw (h_sync_raw),
    .v_sync_raw (v_sync_raw),
    .h_cnt      (h_cnt),
    .h_tot      (live_cfg.h.total)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

    localparam int PPC = 4;
    localparam int DEFV[8] = '{2, 4, 14, 16, 1, 2, 8, 9};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        hsync_pol = 1'b1;
    logic        vsync_pol = 1'b1;
    logic        csync_xor = 1'b0;
    logic        hsync, vsync, csync, blank, active, line_start, frame_start, cfg_err;
    logic [15:0] col, row;
    logic [17:0] pix_x;

    always #2 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .csync_xor(csync_xor),
        .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank), .active(active),
        .line_start(line_start), .frame_start(frame_start), .cfg_err(cfg_err),
        .col(col), .row(row), .pix_x(pix_x)
    );

    int checks = 0;
    int errors = 0;
    int m_h = 0;
    int m_v = 0;
    int m_sh[8];
    int m_live[8];
    bit cmp_en = 0;
    bit done = 0;
    logic prev_vs = 1'b0;
    logic prev_vpol = 1'b1;
    bit   prev_ok = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit axis_good(int b);
        return m_live[b] > 0 && m_live[b] < m_live[b+1] &&
               m_live[b+1] < m_live[b+2] && m_live[b+2] < m_live[b+3];
    endfunction

    // reference model of the counts, advanced on the clock edge
    always @(posedge clk) begin
        int  old_sh[8];
        bit  good, hw, fw;
        old_sh = m_sh;
        if (rst) begin
            m_h = 0; m_v = 0; m_sh = DEFV; m_live = DEFV;
        end else begin
            good = axis_good(0) && axis_good(4);
            if (!good) begin
                m_h = 0; m_v = 0; m_live = old_sh;
            end else begin
                hw = (m_h == m_live[3] - 1);
                fw = hw && (m_v == m_live[7] - 1);
                m_h = hw ? 0 : m_h + 1;
                if (hw) m_v = fw ? 0 : m_v + 1;
                if (fw) m_live = old_sh;
            end
            if (wr_en) m_sh[wr_addr] = wr_data;
        end
        cmp_en = 1;
    end

    // compare all outputs away from the active edge
    always @(negedge clk) begin
        bit err, hs, vs, hb, vb, bl, ls, fs;
        logic hse, vse, cse;
        int c, r;
        string t_sync;
        if (cmp_en && !done) begin
            err = !(axis_good(0) && axis_good(4));
            hs  = !rst && !err && (m_h < m_live[0]);
            vs  = !rst && !err && (m_v < m_live[4]);
            hb  = (m_h < m_live[1]) || (m_h >= m_live[2]);
            vb  = (m_v < m_live[5]) || (m_v >= m_live[6]);
            bl  = rst || err || hb || vb;
            ls  = !rst && !err && (m_h == 0);
            fs  = ls && (m_v == 0);
            c   = bl ? 0 : m_h - m_live[1];
            r   = bl ? 0 : m_v - m_live[5];
            hse = hsync_pol ? hs : !hs;
            vse = vsync_pol ? vs : !vs;
            cse = csync_xor ? (hse ^ vse) : (hse | vse);
            t_sync = rst ? "R11 sync" : ((hsync_pol && vsync_pol) ? "R3 sync" : "R6 sync");
            check("R5 cfg_err", cfg_err, err);
            check(rst ? "R11 blank" : "R4 blank", blank, bl);
            check(rst ? "R11 active" : "R4 active", active, !bl);
            check({t_sync, " h"}, hsync, hse);
            check({t_sync, " v"}, vsync, vse);
            check("R7 csync", csync, cse);
            check("R2 line_start", line_start, ls);
            check("R9 frame_start", frame_start, fs);
            check("R10 col", col, c);
            check("R10 row", row, r);
            check("R10 pix_x", pix_x, c * PPC);
            if (!rst && prev_ok && !cfg_err && vsync_pol == prev_vpol && vsync !== prev_vs)
                check("R8 vsync edge on line boundary", line_start, 1'b1);
            prev_vs   = vsync;
            prev_vpol = vsync_pol;
            prev_ok   = !rst && !cfg_err;
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // width of hsync from a line start; skip_frame picks a non-first line
    task automatic hsync_width(input bit want_frame, output int w);
        do @(negedge clk); while (!(line_start && (frame_start == want_frame)));
        w = 0;
        while (hsync === 1'b1) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int w;
        idle(4);
        // R11: reset state observed at the ports
        check("R11 blank in reset", blank, 1'b1);
        check("R11 line_start in reset", line_start, 1'b0);
        rst = 1'b0;
        idle(300);

        // R1: a mid-frame write waits for the frame wrap
        do @(negedge clk); while (!frame_start);
        idle(20);
        wr(0, 3);
        hsync_width(1'b0, w);
        check("R1 old sync width before wrap", w, 2);
        hsync_width(1'b1, w);
        check("R1 new sync width after wrap", w, 3);
        idle(200);

        // sweep small ordered configurations and output modes
        for (int i = 0; i < 16; i++) begin
            int hes, heb, hsb, ht, ves, veb, vsb, vt;
            hes = 1 + i[0];
            heb = hes + 1 + i[1];
            hsb = heb + 1 + i[2];
            ht  = hsb + 1 + i[3];
            ves = 1 + (i % 3 == 0);
            veb = ves + 1 + i[1];
            vsb = veb + 2 + i[0];
            vt  = vsb + 1 + i[2];
            @(posedge clk); #1;
            hsync_pol = i[0]; vsync_pol = i[1]; csync_xor = i[2];
            wr(0, hes); wr(1, heb); wr(2, hsb); wr(3, ht);
            wr(4, ves); wr(5, veb); wr(6, vsb); wr(7, vt);
            idle(3 * 16 * 9 + 3 * ht * vt);
        end

        // R5: blank end not above sync end is rejected
        @(posedge clk); #1;
        hsync_pol = 1'b1; vsync_pol = 1'b0; csync_xor = 1'b1;
        wr(1, 1);
        idle(400);
        check("R5 misordered words raise the flag", cfg_err, 1'b1);
        check("R5 display stays blanked", blank, 1'b1);
        // while in error, writes apply at once
        wr(1, 3); wr(0, 1);
        idle(2);
        check("R5 repaired words clear the flag", cfg_err, 1'b0);
        idle(500);

        // vertical axis misordered too, then restore defaults
        wr(6, 1);
        idle(300);
        check("R5 vertical misorder flagged", cfg_err, 1'b1);
        for (int k = 0; k < 8; k++) wr(k, DEFV[k]);
        idle(400);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule